// File: doc/BRIEF.md
# Capture Qualifier Condition Matcher

This block sits in front of the sample store of a logic-analyzer style capture unit. On every sample clock it decides whether the current sample may be kept. It watches a group of single-bit probes and a group of multibit probes. Each probe can be switched in or out of the condition at run time. A single-bit probe is matched against a level or an edge. A multibit probe is matched against a programmed value, and any bit of that value can be marked as ignored.

The per-probe results are ANDed into one qualifier. A global switch can turn the whole condition off, and then every sample qualifies. The qualifier leaves the block through a register. The sample word passes through a register of the same depth, so the qualifier and its data arrive in the same cycle. Configuration is loaded through a plain write port.

Top module: `cq_capture_qual`

## Requirements
- R1: When the global enable (address 0, bit 0) is clear, `cap_valid` is 1 for every sample, whatever the probes or the probe settings.
- R2: A probe whose enable bit is clear has no effect on `cap_valid`, whatever its input, mode, value or mask.
- R3: Single-bit probe i is configured at address 8+i, with bit 0 as its enable and bits 3:1 as its mode. Mode 0 matches when the input is 0, and mode 1 matches when the input is 1.
- R4: Mode 2 matches a 0-to-1 change, mode 3 a 1-to-0 change, and mode 4 either change. Each change is measured between the current sample and the sample of the previous clock.
- R5: Mode codes 5, 6 and 7 never match. An enabled probe set to one of them holds `cap_valid` at 0 while the global enable is set.
- R6: Multibit probe j uses three addresses: enable at 32+4j (bit 0), value at 33+4j, and mask at 34+4j. It matches when the input equals the value on every bit whose mask bit is 0. Bits whose mask bit is 1 are ignored.
- R7: With the global enable set, `cap_valid` is 1 only when every enabled probe matches in the same sample.
- R8: With the global enable set and no probe enabled, `cap_valid` is 1.
- R9: `cap_valid` and `cap_data` describe the sample presented one clock earlier. `cap_data` equals the `smp_data` of that sample.
- R10: A configuration write takes effect from the sample after the write cycle. A write does not disturb the edge history: the sample taken during the write cycle serves as the previous value for edge detection.
- R11: While reset is asserted, `cap_valid` and `cap_data` are 0. Reset clears every configuration register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock |
| rst | input | 1 | Synchronous reset, active high |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | 6 | Configuration register address |
| cfg_wdata | input | CFG_W | Configuration write data |
| bit_probe | input | NUM_BIT | Single-bit probe inputs |
| bus_probe | input | NUM_BUS*BUS_W | Multibit probe inputs, probe j in bits j*BUS_W upward |
| smp_data | input | DATA_W | Sample word that travels alongside the qualifier |
| cap_valid | output | 1 | Capture qualifier for the sample one clock earlier |
| cap_data | output | DATA_W | Sample word aligned with `cap_valid` |

## Verification
The assertions assume that the inputs are sampled once per clock and that reset is held for at least one edge before the checks begin. They also assume that configuration writes change the internal enable and mode registers only at clock edges. The bench changes the probes, the sample word and the write port one time unit after each rising edge and never near an edge. Each write is held for exactly one cycle, so every sample that the assertions inspect has a single well-defined previous sample and a single active configuration.

// File: rtl/cq_pkg.sv
package cq_pkg;

    localparam int CFG_AW     = 6;
    localparam int BIT_BASE   = 8;
    localparam int BUS_BASE   = 32;
    localparam int BUS_STRIDE = 4;

    typedef enum logic [2:0] {
        MODE_LOW  = 3'd0,
        MODE_HIGH = 3'd1,
        MODE_RISE = 3'd2,
        MODE_FALL = 3'd3,
        MODE_BOTH = 3'd4
    } bit_mode_e;

    typedef struct packed {
        logic       cur;
        logic       prev;
    } bit_hist_t;

    function automatic logic mode_hit(logic [2:0] mode, bit_hist_t h);
        logic r;
        case (mode)
            MODE_LOW:  r = !h.cur;
            MODE_HIGH: r = h.cur;
            MODE_RISE: r = h.cur && !h.prev;
            MODE_FALL: r = !h.cur && h.prev;
            MODE_BOTH: r = h.cur ^ h.prev;
            default:   r = 1'b0;
        endcase
        return r;
    endfunction

endpackage

// File: rtl/cq_cfg_regs.sv
module cq_cfg_regs
    import cq_pkg::*;
#(
    parameter int NUM_BIT = 4,
    parameter int NUM_BUS = 2,
    parameter int BUS_W   = 8,
    parameter int CFG_W   = 8
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     cfg_we,
    input  logic [CFG_AW-1:0]        cfg_addr,
    input  logic [CFG_W-1:0]         cfg_wdata,
    output logic                     glob_en,
    output logic [NUM_BIT-1:0]       bit_en,
    output logic [NUM_BIT*3-1:0]     bit_mode,
    output logic [NUM_BUS-1:0]       bus_en,
    output logic [NUM_BUS*BUS_W-1:0] bus_val,
    output logic [NUM_BUS*BUS_W-1:0] bus_mask
);

    always_ff @(posedge clk) begin
        if (rst) begin
            glob_en <= 1'b0;
        end else if (cfg_we && cfg_addr == CFG_AW'(0)) begin
            glob_en <= cfg_wdata[0];
        end
    end

    for (genvar i = 0; i < NUM_BIT; i++) begin : g_bit
        logic       en_q;
        logic [2:0] mode_q;
        always_ff @(posedge clk) begin
            if (rst) begin
                en_q   <= 1'b0;
                mode_q <= 3'd0;
            end else if (cfg_we && cfg_addr == CFG_AW'(BIT_BASE + i)) begin
                en_q   <= cfg_wdata[0];
                mode_q <= cfg_wdata[3:1];
            end
        end
        assign bit_en[i]        = en_q;
        assign bit_mode[3*i+:3] = mode_q;
    end

    for (genvar j = 0; j < NUM_BUS; j++) begin : g_bus
        localparam int BASE = BUS_BASE + BUS_STRIDE * j;
        logic             en_q;
        logic [BUS_W-1:0] val_q;
        logic [BUS_W-1:0] mask_q;
        always_ff @(posedge clk) begin
            if (rst) begin
                en_q   <= 1'b0;
                val_q  <= '0;
                mask_q <= '0;
            end else if (cfg_we) begin
                if (cfg_addr == CFG_AW'(BASE))     en_q   <= cfg_wdata[0];
                if (cfg_addr == CFG_AW'(BASE + 1)) val_q  <= cfg_wdata[BUS_W-1:0];
                if (cfg_addr == CFG_AW'(BASE + 2)) mask_q <= cfg_wdata[BUS_W-1:0];
            end
        end
        assign bus_en[j]               = en_q;
        assign bus_val[j*BUS_W+:BUS_W]  = val_q;
        assign bus_mask[j*BUS_W+:BUS_W] = mask_q;
    end

endmodule

// File: rtl/cq_bit_match.sv
module cq_bit_match
    import cq_pkg::*;
#(
    parameter int NUM_BIT = 4
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic [NUM_BIT-1:0]   probe,
    input  logic [NUM_BIT-1:0]   en,
    input  logic [NUM_BIT*3-1:0] mode,
    output logic [NUM_BIT-1:0]   hit
);

    logic [NUM_BIT-1:0] prev_q;

    always_ff @(posedge clk) begin
        if (rst) prev_q <= '0;
        else     prev_q <= probe;
    end

    for (genvar i = 0; i < NUM_BIT; i++) begin : g_hit
        bit_hist_t h;
        assign h      = '{cur: probe[i], prev: prev_q[i]};
        assign hit[i] = !en[i] || mode_hit(mode[3*i+:3], h);
    end

endmodule

// File: rtl/cq_bus_match.sv
module cq_bus_match #(
    parameter int NUM_BUS = 2,
    parameter int BUS_W   = 8
) (
    input  logic [NUM_BUS*BUS_W-1:0] probe,
    input  logic [NUM_BUS-1:0]       en,
    input  logic [NUM_BUS*BUS_W-1:0] val,
    input  logic [NUM_BUS*BUS_W-1:0] mask,
    output logic [NUM_BUS-1:0]       hit
);

    for (genvar j = 0; j < NUM_BUS; j++) begin : g_cmp
        logic [BUS_W-1:0] diff;
        assign diff   = (probe[j*BUS_W+:BUS_W] ^ val[j*BUS_W+:BUS_W]) & ~mask[j*BUS_W+:BUS_W];
        assign hit[j] = !en[j] || (diff == '0);
    end

endmodule

// File: rtl/cq_capture_qual.sv
module cq_capture_qual
    import cq_pkg::*;
#(
    parameter int NUM_BIT = 4,
    parameter int NUM_BUS = 2,
    parameter int BUS_W   = 8,
    parameter int DATA_W  = 16,
    parameter int CFG_W   = (BUS_W < 4) ? 4 : BUS_W
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     cfg_we,
    input  logic [CFG_AW-1:0]        cfg_addr,
    input  logic [CFG_W-1:0]         cfg_wdata,
    input  logic [NUM_BIT-1:0]       bit_probe,
    input  logic [NUM_BUS*BUS_W-1:0] bus_probe,
    input  logic [DATA_W-1:0]        smp_data,
    output logic                     cap_valid,
    output logic [DATA_W-1:0]        cap_data
);

    logic                     glob_en;
    logic [NUM_BIT-1:0]       bit_en;
    logic [NUM_BIT*3-1:0]     bit_mode;
    logic [NUM_BUS-1:0]       bus_en;
    logic [NUM_BUS*BUS_W-1:0] bus_val;
    logic [NUM_BUS*BUS_W-1:0] bus_mask;
    logic [NUM_BIT-1:0]       bit_hit;
    logic [NUM_BUS-1:0]       bus_hit;
    logic                     any_en;
    logic                     qual;

    cq_cfg_regs #(
        .NUM_BIT(NUM_BIT), .NUM_BUS(NUM_BUS), .BUS_W(BUS_W), .CFG_W(CFG_W)
    ) u_cfg (
        .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
        .cfg_wdata(cfg_wdata), .glob_en(glob_en), .bit_en(bit_en),
        .bit_mode(bit_mode), .bus_en(bus_en), .bus_val(bus_val),
        .bus_mask(bus_mask)
    );

    cq_bit_match #(.NUM_BIT(NUM_BIT)) u_bit (
        .clk(clk), .rst(rst), .probe(bit_probe), .en(bit_en),
        .mode(bit_mode), .hit(bit_hit)
    );

    cq_bus_match #(.NUM_BUS(NUM_BUS), .BUS_W(BUS_W)) u_bus (
        .probe(bus_probe), .en(bus_en), .val(bus_val), .mask(bus_mask),
        .hit(bus_hit)
    );

    assign any_en = |{bit_en, bus_en};
    assign qual   = !glob_en || (&{bit_hit, bus_hit});

    always_ff @(posedge clk) begin
        if (rst) begin
            cap_valid <= 1'b0;
            cap_data  <= '0;
        end else begin
            cap_valid <= qual;
            cap_data  <= smp_data;
        end
    end

endmodule

// File: rtl/cq_capture_qual_chk.sv
module cq_capture_qual_chk #(
    parameter int NUM_BIT = 4,
    parameter int DATA_W  = 16
) (
    input logic                 clk,
    input logic                 rst,
    input logic                 glob_en,
    input logic                 any_en,
    input logic [NUM_BIT-1:0]   bit_en,
    input logic [NUM_BIT*3-1:0] bit_mode,
    input logic [DATA_W-1:0]    smp_data,
    input logic                 cap_valid,
    input logic [DATA_W-1:0]    cap_data
);

    logic pv;
    logic started = 1'b0;

    always_ff @(posedge clk) begin
        if (rst) pv <= 1'b0;
        else     pv <= 1'b1;
        started <= 1'b1;
    end

    AST_RESET_CLEAR: assert property (@(posedge clk)
        (started && $past(rst)) |-> (!cap_valid && cap_data == '0)); // R11

    AST_GLOBAL_OFF: assert property (@(posedge clk) disable iff (rst)
        (pv && !$past(glob_en)) |-> cap_valid); // R1

    AST_NONE_ENABLED: assert property (@(posedge clk) disable iff (rst)
        (pv && $past(glob_en) && !$past(any_en)) |-> cap_valid); // R8

    AST_DATA_ALIGN: assert property (@(posedge clk) disable iff (rst)
        pv |-> (cap_data == $past(smp_data))); // R9

    for (genvar i = 0; i < NUM_BIT; i++) begin : g_inv
        AST_BAD_MODE: assert property (@(posedge clk) disable iff (rst)
            (pv && $past(glob_en) && $past(bit_en[i]) && $past(bit_mode[3*i+:3]) > 3'd4)
            |-> !cap_valid); // R5
    end

endmodule

bind cq_capture_qual cq_capture_qual_chk #(
    .NUM_BIT(NUM_BIT), .DATA_W(DATA_W)
) u_chk (
    .clk(clk), .rst(rst), .glob_en(glob_en), .any_en(any_en),
    .bit_en(bit_en), .bit_mode(bit_mode), .smp_data(smp_data),
    .cap_valid(cap_valid), .cap_data(cap_data)
);

// File: tb/test_cq_capture_qual.sv
module test_cq_capture_qual;

    localparam int NUM_BIT = 4;
    localparam int NUM_BUS = 2;
    localparam int BUS_W   = 8;
    localparam int DATA_W  = 16;

    logic                     clk = 1'b0;
    logic                     rst = 1'b1;
    logic                     cfg_we = 1'b0;
    logic [5:0]               cfg_addr = '0;
    logic [BUS_W-1:0]         cfg_wdata = '0;
    logic [NUM_BIT-1:0]       bit_probe = '0;
    logic [NUM_BUS*BUS_W-1:0] bus_probe = '0;
    logic [DATA_W-1:0]        smp_data = 16'h1000;
    logic                     cap_valid;
    logic [DATA_W-1:0]        cap_data;

    int checks = 0;
    int fails = 0;
    logic [DATA_W-1:0] last_smp;

    always #5 clk = ~clk;

    cq_capture_qual #(
        .NUM_BIT(NUM_BIT), .NUM_BUS(NUM_BUS), .BUS_W(BUS_W), .DATA_W(DATA_W)
    ) i_cq_capture_qual (
        .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
        .cfg_wdata(cfg_wdata), .bit_probe(bit_probe), .bus_probe(bus_probe),
        .smp_data(smp_data), .cap_valid(cap_valid), .cap_data(cap_data)
    );

    task automatic check(string req, logic [31:0] got, logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s got=%0h exp=%0h", req, got, exp);
        end
    endtask

    task automatic step();
        last_smp = smp_data;
        @(posedge clk);
        #1;
        smp_data = smp_data + 16'h0101;
    endtask

    task automatic cyc(string req, logic exp_v);
        step();
        check(req, {31'd0, cap_valid}, {31'd0, exp_v});
        check("R9", {16'd0, cap_data}, {16'd0, last_smp});
    endtask

    task automatic wr(int addr, int data);
        cfg_we    = 1'b1;
        cfg_addr  = 6'(addr);
        cfg_wdata = BUS_W'(data);
        step();
        cfg_we    = 1'b0;
    endtask

    function automatic logic edge_exp(int mode, logic cur, logic prev);
        case (mode)
            0: return !cur;
            1: return cur;
            2: return cur && !prev;
            3: return !cur && prev;
            4: return cur ^ prev;
            default: return 1'b0;
        endcase
    endfunction

    task automatic drive_b0(string req, int mode, logic v);
        logic e;
        e = edge_exp(mode, v, bit_probe[0]);
        bit_probe[0] = v;
        cyc(req, e);
    endtask

    task automatic t_reset();
        rst = 1'b1;
        repeat (3) step();
        check("R11", {31'd0, cap_valid}, 32'd0);
        check("R11", {16'd0, cap_data}, 32'd0);
        rst = 1'b0;
    endtask

    task automatic t_global_off();
        bit_probe = 4'b1010; bus_probe = 16'h5AA5;
        cyc("R1", 1'b1);
        bit_probe = 4'b0101; bus_probe = 16'h0000;
        cyc("R1", 1'b1);
        wr(8, 11);
        wr(32, 1); wr(33, 8'h77);
        bit_probe = 4'b0000; bus_probe = 16'h0011;
        cyc("R1", 1'b1);
        wr(8, 0); wr(32, 0); wr(33, 0);
    endtask

    task automatic t_none_enabled();
        wr(0, 1);
        bit_probe = 4'b1111; bus_probe = 16'hFFFF;
        cyc("R8", 1'b1);
        bit_probe = 4'b0000; bus_probe = 16'h1234;
        cyc("R8", 1'b1);
    endtask

    task automatic t_level();
        wr(8, (1 << 1) | 1);
        drive_b0("R3", 1, 1'b1);
        drive_b0("R3", 1, 1'b0);
        wr(8, (0 << 1) | 1);
        drive_b0("R3", 0, 1'b0);
        drive_b0("R3", 0, 1'b1);
    endtask

    task automatic t_edges();
        for (int m = 2; m <= 4; m++) begin
            wr(8, (m << 1) | 1);
            drive_b0("R4", m, 1'b0);
            drive_b0("R4", m, 1'b1);
            drive_b0("R4", m, 1'b1);
            drive_b0("R4", m, 1'b0);
            drive_b0("R4", m, 1'b0);
        end
    endtask

    task automatic t_bad_mode();
        for (int m = 5; m <= 7; m++) begin
            wr(8, (m << 1) | 1);
            bit_probe[0] = 1'b1;
            cyc("R5", 1'b0);
            bit_probe[0] = 1'b0;
            cyc("R5", 1'b0);
        end
        wr(8, (5 << 1) | 0);
        cyc("R2", 1'b1);
    endtask

    task automatic t_masked();
        wr(32, 1); wr(33, 17); wr(34, 0);
        bus_probe[7:0] = 8'd17;
        cyc("R6", 1'b1);
        bus_probe[7:0] = 8'd18;
        cyc("R6", 1'b0);
        wr(34, 8'h0F);
        bus_probe[7:0] = 8'h1A;
        cyc("R6", 1'b1);
        bus_probe[7:0] = 8'h21;
        cyc("R6", 1'b0);
        wr(32, 0);
        cyc("R2", 1'b1);
        wr(34, 0);
    endtask

    task automatic t_and();
        wr(32, 1);
        wr(8, (1 << 1) | 1);
        bit_probe[0] = 1'b1; bus_probe[7:0] = 8'd17;
        cyc("R7", 1'b1);
        bit_probe[0] = 1'b0;
        cyc("R7", 1'b0);
        bit_probe[0] = 1'b1; bus_probe[7:0] = 8'd16;
        cyc("R7", 1'b0);
        bit_probe[0] = 1'b0;
        cyc("R7", 1'b0);
        wr(32, 0);
    endtask

    task automatic t_cfg_timing();
        bit_probe[0] = 1'b0;
        wr(8, (1 << 1) | 1);
        cyc("R10", 1'b0);
        cfg_we = 1'b1; cfg_addr = 6'd8; cfg_wdata = 8'((2 << 1) | 1);
        step();
        cfg_we = 1'b0;
        check("R10", {31'd0, cap_valid}, 32'd0);
        bit_probe[0] = 1'b1;
        cyc("R10", 1'b1);
        cyc("R10", 1'b0);
        cfg_we = 1'b1; cfg_addr = 6'd8; cfg_wdata = 8'd0;
        bit_probe[0] = 1'b0;
        step();
        cfg_we = 1'b0;
        check("R10", {31'd0, cap_valid}, 32'd0);
        cyc("R10", 1'b1);
    endtask

    task automatic t_reset_clears();
        wr(8, (5 << 1) | 1);
        cyc("R5", 1'b0);
        rst = 1'b1;
        step();
        rst = 1'b0;
        bit_probe = 4'b0000;
        cyc("R11", 1'b1);
    endtask

    logic done = 1'b0;

    initial begin
        t_reset();
        t_global_off();
        t_none_enabled();
        t_level();
        t_edges();
        t_bad_mode();
        t_masked();
        t_and();
        t_cfg_timing();
        t_reset_clears();
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog got=running exp=done");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

endmodule